// File: doc/BRIEF.md
# Per-CPU Interrupt Pending Register Bank

This block keeps one 32-bit pending word for each CPU of a small multiprocessor and exposes all of them through one memory-mapped window. Every CPU owns a 4 KB page of that window. Inside the page, a status word can be read back, one write offset sets software interrupt bits and another clears them. The low half of each word holds hardware interrupt levels. A system interrupt router sets and clears those bits through a separate side port. The bus cannot clear them.

The software bits sit in bits 31..17 of the word. Each one is shifted down by 16 and drives one request line, for levels 15 down to 1, of its CPU's priority request vector. A clear of the level-15 software bit can also be asked for through bit 14 of the clear data. That bit stands in for bit 31, which is the bit actually cleared. Read data is registered and appears one cycle after the read strobe.

Top module: `pend_regs`

## Requirements
- R1: The CPU is selected by address bits [12 +: log2(NUM_CPUS)], and the word offset within the page by address bits [3:2]. Address bits [11:4] and [1:0] are ignored.
- R2: A read strobe at offset 0 puts the addressed CPU's pending word on bus_rdata in the following cycle. A read at offsets 1, 2 or 3 returns zero. bus_rdata holds its value when no read is strobed.
- R3: A write at offset 2 ORs (wdata & 0xFFFE0000) into the addressed CPU's pending word.
- R4: A write at offset 1 clears the bits of (wdata & 0xFFFE0000) in the addressed CPU's pending word. Bits [16:0] are never changed by the bus.
- R5: In an offset-1 write with wdata bit 14 set, bit 31 is cleared as though wdata bit 31 were also set.
- R6: level_req[c*15 + (L-1)] equals bit L+16 of CPU c's pending word, for levels L = 1..15.
- R7: A side-port set of level L (1..15) sets bit L of the chosen CPU's word. A side-port clear of level L clears that bit. Level 0 has no effect.
- R8: A side-port set and a side-port clear of the same CPU and level in the same cycle leave the bit set.
- R9: Writes at offset 3 change no pending word.
- R10: Reset, synchronous and active high, clears every pending word, level_req and bus_rdata to zero.
- R11: A bus write changes only the addressed CPU's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12+log2(NUM_CPUS) | Byte address within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hw_set_valid | input | 1 | Side-port set strobe |
| hw_set_cpu | input | log2(NUM_CPUS) | CPU targeted by the set |
| hw_set_level | input | 4 | Level to set |
| hw_clr_valid | input | 1 | Side-port clear strobe |
| hw_clr_cpu | input | log2(NUM_CPUS) | CPU targeted by the clear |
| hw_clr_level | input | 4 | Level to clear |
| level_req | output | 15*NUM_CPUS | Per-CPU level request vectors from software bits |

## Verification
The directed cases go after the spots where a wrong design stays quiet.

- Bit 14 in clear data: the bench clears with only bit 14 set. A design without the alias would leave the level-15 request stuck high, and one that clears bit 14 itself would wipe a hardware level-14 bit.
- Out-of-mask data bits: the bench writes all-ones to the set and clear offsets. A design that leaks the low-half bits would change hardware levels, and one that leaks bit 16 would show up in readback.
- Offset 3 and ignored address bits: the bench writes to offset 3 and reads with random filler in address bits [11:4]. A design that maps offset 3 or decodes the filler bits would corrupt other words.
- Colliding side-port strobes: the bench issues a set and a clear of the same level together. A design with the wrong order would drop the bit.
- Random traffic: mixed bus and side-port operations across all CPUs catch wrong CPU selection or cross-CPU writes.

// File: rtl/pend_pkg.sv
package pend_pkg;

    localparam int WORD_W      = 32;
    localparam int LEVELS      = 15;
    localparam int LVL_W       = $clog2(LEVELS + 1);
    localparam int PAGE_SHIFT  = 12;
    localparam int SOFT_SHIFT  = 16;
    localparam int ALIAS_SRC   = 14;
    localparam int ALIAS_DST   = 31;

    localparam logic [WORD_W-1:0] SOFT_MASK = 32'hFFFE_0000;
    localparam logic [WORD_W-1:0] HARD_MASK = 32'h0000_FFFE;

    // Word offsets inside a CPU page (address bits [3:2])
    typedef enum logic [1:0] {
        OFS_STATUS = 2'd0,
        OFS_CLEAR  = 2'd1,
        OFS_SET    = 2'd2,
        OFS_SPARE  = 2'd3
    } ofs_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        ofs_e              ofs;
        logic [WORD_W-1:0] data;
    } bus_op_t;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] level;
    } hw_op_t;

    // Clear data: bit 14 stands in for bit 31, then keep soft bits only
    function automatic logic [WORD_W-1:0] clear_bits(input logic [WORD_W-1:0] d);
        logic [WORD_W-1:0] m;
        m = d;
        if (m[ALIAS_SRC]) m[ALIAS_DST] = 1'b1;
        return m & SOFT_MASK;
    endfunction

    function automatic logic [WORD_W-1:0] set_bits(input logic [WORD_W-1:0] d);
        return d & SOFT_MASK;
    endfunction

    // One-hot hardware level bit; level 0 falls outside the mask
    function automatic logic [WORD_W-1:0] level_bit(input logic [LVL_W-1:0] lvl);
        logic [WORD_W-1:0] b;
        b = WORD_W'(1) << lvl;
        return b & HARD_MASK;
    endfunction

    // Software bits [31:17] folded down to levels 15..1 (index 0 = level 1)
    function automatic logic [LEVELS-1:0] fold_soft(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] s;
        s = (w & SOFT_MASK) >> SOFT_SHIFT;
        return s[LEVELS:1];
    endfunction

endpackage

// File: rtl/pend_decode.sv
module pend_decode
    import pend_pkg::*;
#(
    parameter int CPU_W = 2
) (
    input  logic                     wr,
    input  logic                     rd,
    input  logic [CPU_W-1:0]         page_bits,
    input  logic [1:0]               word_bits,
    input  logic [WORD_W-1:0]        wdata,
    output logic [CPU_W-1:0]         cpu_idx,
    output bus_op_t                  op
);

    always_comb begin
        cpu_idx = page_bits;
        op.wr   = wr;
        op.rd   = rd;
        op.ofs  = ofs_e'(word_bits);
        op.data = wdata;
    end

endmodule

// File: rtl/pend_word.sv
module pend_word
    import pend_pkg::*;
#(
    parameter int CPU_W  = 2,
    parameter int CPU_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           op,
    input  logic [CPU_W-1:0]  op_cpu,
    input  hw_op_t            hw_set,
    input  logic [CPU_W-1:0]  hw_set_cpu,
    input  hw_op_t            hw_clr,
    input  logic [CPU_W-1:0]  hw_clr_cpu,
    output logic [WORD_W-1:0] pend,
    output logic [LEVELS-1:0] req
);

    localparam logic [CPU_W-1:0] MY_ID = CPU_W'(CPU_ID);

    logic              bus_hit;
    logic [WORD_W-1:0] set_v;
    logic [WORD_W-1:0] clr_v;
    logic [WORD_W-1:0] pend_d;

    assign bus_hit = op.wr && (op_cpu == MY_ID);

    always_comb begin
        set_v = '0;
        clr_v = '0;
        if (bus_hit && op.ofs == OFS_SET)
            set_v = set_v | set_bits(op.data);
        if (bus_hit && op.ofs == OFS_CLEAR)
            clr_v = clr_v | clear_bits(op.data);
        if (hw_clr.valid && hw_clr_cpu == MY_ID)
            clr_v = clr_v | level_bit(hw_clr.level);
        if (hw_set.valid && hw_set_cpu == MY_ID)
            set_v = set_v | level_bit(hw_set.level);
        // set is applied after clear, so a set wins a collision
        pend_d = (pend & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= pend_d;
    end

    assign req = fold_soft(pend);

endmodule

// File: rtl/pend_regs.sv
module pend_regs
    import pend_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int ADDR_W  = PAGE_SHIFT + CPU_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [WORD_W-1:0]          bus_wdata,
    output logic [WORD_W-1:0]          bus_rdata,
    input  logic                       hw_set_valid,
    input  logic [CPU_W-1:0]           hw_set_cpu,
    input  logic [LVL_W-1:0]           hw_set_level,
    input  logic                       hw_clr_valid,
    input  logic [CPU_W-1:0]           hw_clr_cpu,
    input  logic [LVL_W-1:0]           hw_clr_level,
    output logic [LEVELS*NUM_CPUS-1:0] level_req
);

    logic [CPU_W-1:0]  cpu_idx;
    bus_op_t           op;
    hw_op_t            hw_set;
    hw_op_t            hw_clr;
    logic [WORD_W-1:0] pend_all [NUM_CPUS];
    logic              unused_addr;

    assign unused_addr = ^{bus_addr[PAGE_SHIFT-1:4], bus_addr[1:0]};

    assign hw_set = '{valid: hw_set_valid, level: hw_set_level};
    assign hw_clr = '{valid: hw_clr_valid, level: hw_clr_level};

    pend_decode #(.CPU_W(CPU_W)) u_decode (
        .wr        (bus_wr),
        .rd        (bus_rd),
        .page_bits (bus_addr[PAGE_SHIFT +: CPU_W]),
        .word_bits (bus_addr[3:2]),
        .wdata     (bus_wdata),
        .cpu_idx   (cpu_idx),
        .op        (op)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        pend_word #(.CPU_W(CPU_W), .CPU_ID(c)) u_word (
            .clk        (clk),
            .rst        (rst),
            .op         (op),
            .op_cpu     (cpu_idx),
            .hw_set     (hw_set),
            .hw_set_cpu (hw_set_cpu),
            .hw_clr     (hw_clr),
            .hw_clr_cpu (hw_clr_cpu),
            .pend       (pend_all[c]),
            .req        (level_req[c*LEVELS +: LEVELS])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (op.rd)
            bus_rdata <= (op.ofs == OFS_STATUS) ? pend_all[cpu_idx] : '0;
    end

endmodule

// File: rtl/pend_regs_chk.sv
module pend_regs_chk
    import pend_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int ADDR_W  = PAGE_SHIFT + CPU_W
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       bus_wr,
    input logic                       bus_rd,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [WORD_W-1:0]          bus_wdata,
    input logic [WORD_W-1:0]          bus_rdata,
    input logic [LEVELS*NUM_CPUS-1:0] level_req
);

    logic [CPU_W-1:0] a_cpu;
    logic [1:0]       a_ofs;
    assign a_cpu = bus_addr[PAGE_SHIFT +: CPU_W];
    assign a_ofs = bus_addr[3:2];

    assert_reset_clear_R10: assert property (@(posedge clk)
        $past(rst) |-> (level_req == '0 && bus_rdata == '0));

    assert_rdata_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && a_ofs != 2'd0) |=> bus_rdata == '0);

    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    assert_req_bus_only_R6: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(level_req));

    assert_spare_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && a_ofs == 2'd3) |=> $stable(level_req));

    assert_set_top_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && a_ofs == 2'd2 && bus_wdata[31])
        |=> level_req[$past(a_cpu)*LEVELS + LEVELS-1]);

    assert_clear_alias_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && a_ofs == 2'd1 && bus_wdata[14])
        |=> !level_req[$past(a_cpu)*LEVELS + LEVELS-1]);

endmodule

bind pend_regs pend_regs_chk #(.NUM_CPUS(NUM_CPUS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .level_req (level_req)
);

// File: tb/pend_regs_bench.sv
module pend_regs_bench;
    import pend_pkg::*;

    localparam int NC     = 4;
    localparam int CW     = 2;
    localparam int AW     = PAGE_SHIFT + CW;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0]        bus_addr = '0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic                 hs_v = 1'b0, hc_v = 1'b0;
    logic [CW-1:0]        hs_cpu = '0, hc_cpu = '0;
    logic [3:0]           hs_lvl = '0, hc_lvl = '0;
    logic [LEVELS*NC-1:0] level_req;

    int unsigned n_chk = 0, n_fail = 0;
    int unsigned seed = 32'd20240611;
    logic [31:0] model [NC];

    always #2.5 clk = ~clk;

    pend_regs #(.NUM_CPUS(NC)) u_pend_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_set_valid(hs_v), .hw_set_cpu(hs_cpu), .hw_set_level(hs_lvl),
        .hw_clr_valid(hc_v), .hw_clr_cpu(hc_cpu), .hw_clr_level(hc_lvl),
        .level_req(level_req)
    );

    function automatic logic [LEVELS*NC-1:0] exp_req();
        logic [LEVELS*NC-1:0] r = '0;
        for (int c = 0; c < NC; c++)
            for (int l = 1; l <= LEVELS; l++)
                r[c*LEVELS + l - 1] = model[c][l+16];
        return r;
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [AW-1:0] mk_addr(input int cpu, input int ofs, input int fill);
        logic [AW-1:0] a = '0;
        a[PAGE_SHIFT +: CW] = CW'(cpu);
        a[3:2]              = 2'(ofs);
        a[11:4]             = 8'(fill);
        a[1:0]              = 2'(fill >> 8);
        return a;
    endfunction

    // One clock: drive at negedge, update model, check after the edge
    task automatic step(input logic wr, input logic rd, input logic [AW-1:0] a,
                        input logic [31:0] d,
                        input logic sv, input int sc, input int sl,
                        input logic cv, input int cc, input int cl,
                        input string tag);
        int cpu, ofs;
        logic [31:0] exp_rd, m, setm, clrm;
        cpu = int'(a[PAGE_SHIFT +: CW]);
        ofs = int'(a[3:2]);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        hs_v = sv; hs_cpu = CW'(sc); hs_lvl = 4'(sl);
        hc_v = cv; hc_cpu = CW'(cc); hc_lvl = 4'(cl);
        exp_rd = (ofs == 0) ? model[cpu] : 32'h0;
        for (int c = 0; c < NC; c++) begin
            setm = '0; clrm = '0;
            if (wr && c == cpu && ofs == 2) setm |= d & 32'hFFFE0000;
            if (wr && c == cpu && ofs == 1) begin
                m = d;
                if (m[14]) m[31] = 1'b1;
                clrm |= m & 32'hFFFE0000;
            end
            if (cv && c == cc && cl >= 1 && cl <= 15) clrm[cl] = 1'b1;
            if (sv && c == sc && sl >= 1 && sl <= 15) setm[sl] = 1'b1;
            model[c] = (model[c] & ~clrm) | setm;
        end
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; hs_v = 1'b0; hc_v = 1'b0;
        if (rd) check(bus_rdata === exp_rd, {tag, " rdata"}, 64'(bus_rdata), 64'(exp_rd));
        check(level_req === exp_req(), {tag, " level_req"}, 64'(level_req), 64'(exp_req()));
    endtask

    task automatic rd_word(input int cpu, input int ofs, input string tag);
        step(1'b0, 1'b1, mk_addr(cpu, ofs, 0), '0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        for (int c = 0; c < NC; c++) model[c] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        check(level_req === '0, "R10 reset level_req", 64'(level_req), 64'h0);
        check(bus_rdata === '0, "R10 reset rdata", 64'(bus_rdata), 64'h0);
        for (int c = 0; c < NC; c++) rd_word(c, 0, "R10 reset word");

        // R3 R11: set all soft bits of CPU 2 only, with filler address bits (R1)
        step(1, 0, mk_addr(2, 2, 'h3A5), 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, "R3 R1 set all");
        rd_word(2, 0, "R3 readback");
        rd_word(1, 0, "R11 other cpu");
        // R6 folded into level_req checked each step
        // R5: bit 14 alone clears bit 31
        step(1, 0, mk_addr(2, 1, 0), 32'h0000_4000, 0, 0, 0, 0, 0, 0, "R5 alias clear");
        rd_word(2, 0, "R5 readback");
        // R7: hardware levels
        step(0, 0, mk_addr(0, 0, 0), 0, 1, 2, 14, 0, 0, 0, "R7 hw set 14");
        step(0, 0, mk_addr(0, 0, 0), 0, 1, 2, 0, 0, 0, 0, "R7 hw level0");
        rd_word(2, 0, "R7 readback");
        // R4: bus clear of all ones leaves bits [16:0]
        step(1, 0, mk_addr(2, 1, 0), 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, "R4 clear all");
        rd_word(2, 0, "R4 readback");
        // R8: colliding side-port set and clear
        step(0, 0, mk_addr(0, 0, 0), 0, 1, 3, 9, 1, 3, 9, "R8 collide");
        rd_word(3, 0, "R8 readback");
        step(0, 0, mk_addr(0, 0, 0), 0, 0, 0, 0, 1, 3, 9, "R7 hw clear");
        rd_word(3, 0, "R7 clear readback");
        // R9: spare offset write ignored; R2: non-status reads are zero
        step(1, 0, mk_addr(1, 3, 0), 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, "R9 spare write");
        rd_word(1, 0, "R9 readback");
        step(1, 0, mk_addr(1, 2, 0), 32'h8002_0000, 0, 0, 0, 0, 0, 0, "R3 set pair");
        for (int o = 1; o < 4; o++) rd_word(1, o, "R2 zero read");

        // Random mix
        void'($urandom(seed));
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = int'($urandom % 4);
            step(op == 1 || op == 2, op == 0 || op == 3,
                 mk_addr(int'($urandom % NC), int'($urandom % 4), int'($urandom % 1024)),
                 $urandom,
                 ($urandom % 3) == 0, int'($urandom % NC), int'($urandom % 16),
                 ($urandom % 3) == 0, int'($urandom % NC), int'($urandom % 16),
                 "R1 R2 R3 R4 R6 R7 R11 random");
        end
        finish_run();
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(5ns * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule